// File: doc/BRIEF.md
# SDRAM Burst Column Address Generator

This block produces the column address for every beat of a synchronous DRAM read or write burst. A command controller pulses `cmd_start` together with the start column and the two burst fields of the mode register. From the next clock on, the block presents one column per clock, with a beat-valid strobe and a flag on the final beat. The data-path logic uses these outputs to address the array one beat at a time.

Bursts have a fixed length of 1, 2, 4 or 8 beats, or run over a full page. In a fixed-length burst the address moves only inside the aligned block that holds the start column. The order inside that block is either counting order or interleaved order, in which the start column is exclusive-ORed with the beat index. A full-page burst keeps counting over the whole 11-bit column space until something stops it. A stop request ends any burst on the next clock. A new command on any cycle drops the current burst and starts the new one.

Top module: `sdram_burst_colgen`

## Requirements
- R1: While reset is held, and after it is released, `beat_valid` and `beat_last` are 0 and `col_out` is 0.
- R2: On the clock edge that samples `cmd_start`=1, the burst begins. From that edge on, `beat_valid`=1 and `col_out` equals the sampled `start_col`. Each later edge moves to the next beat.
- R3: `bl_code` with bit 2 clear gives a burst of 2^`bl_code[1:0]` beats: 0→1, 1→2, 2→4, 3→8. With bit 2 set it selects full page.
- R4: Sequential order (`intl_sel`=0): the low log2(BL) bits of beat k are (start + k) mod BL. The higher column bits stay equal to those of `start_col`. Example: BL=4 from 2 gives 2,3,0,1.
- R5: Interleaved order (`intl_sel`=1): the low log2(BL) bits of beat k are start XOR k, and the higher bits are held. Example: BL=8 from 5 gives 5,4,7,6,1,0,3,2.
- R6: A full-page burst gives beat k = (start + k) mod 2048. It continues until it is stopped or replaced, and `beat_last` stays 0 the whole time.
- R7: In full-page mode `intl_sel` is ignored and the order is sequential.
- R8: `beat_last`=1 only on the final beat of a fixed-length burst. On the edge after that beat, `beat_valid` returns to 0 unless a new command is sampled.
- R9: `cmd_stop`=1 sampled without `cmd_start` makes `beat_valid` 0 from that edge on.
- R10: `cmd_start` sampled during a burst restarts at the new start column with the new mode. When `cmd_start` and `cmd_stop` are sampled together, the start takes effect and the stop is ignored.
- R11: The length and order are captured at the command. Changes to `bl_code` or `intl_sel` during a burst do not alter the running sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| cmd_start | input | 1 | Read or write command: begin a burst |
| cmd_stop | input | 1 | Burst-terminate request |
| start_col | input | 11 | Start column of the command |
| bl_code | input | 3 | Burst-length field (0..3 fixed, bit 2 set = full page) |
| intl_sel | input | 1 | Burst order: 0 sequential, 1 interleaved |
| col_out | output | 11 | Column of the current beat |
| beat_valid | output | 1 | A beat is presented this cycle |
| beat_last | output | 1 | The current beat is the final one of a fixed burst |

## Verification
The assertions expect `cmd_start`, `cmd_stop` and the mode inputs to be stable, known values at each rising edge. They do not assume the two commands are exclusive. The priority between them is part of what is checked. The stimulus drives every input on the falling edge only and holds a command for exactly one clock. It also issues commands in the middle of bursts and on the same cycle as a stop, so the restart and priority paths are exercised inside these assumptions.

// File: rtl/colgen_pkg.sv
// Package: shared encodings for the burst column generator.
// Assumes: the mode field layout given in the brief (bit 2 of the length code selects full page).
package colgen_pkg;
    typedef enum logic {
        ORD_SEQ  = 1'b0,
        ORD_INTL = 1'b1
    } burst_order_e;

    localparam int LEN_FIELD_W   = 3;
    localparam int FULL_PAGE_BIT = 2;
    localparam int LOG_LEN_W     = 2;
endpackage

// File: rtl/colgen_mode_dec.sv
// Module: colgen_mode_dec
// Turns the length and order fields into a column mask, a full-page flag and an order.
// Assumes: a full page spans every column bit, and full page forces sequential order.
module colgen_mode_dec
    import colgen_pkg::*;
#(
    parameter int COL_W = 11
) (
    input  logic [LEN_FIELD_W-1:0] len_code,
    input  logic                   order_in,
    output logic [COL_W-1:0]       wrap_mask,
    output logic                   full_page,
    output burst_order_e           order_out
);
    logic [LOG_LEN_W-1:0] log_len;

    // Purpose: decode the length field into a wrap mask.
    always_comb begin
        full_page = len_code[FULL_PAGE_BIT];
        log_len   = len_code[LOG_LEN_W-1:0];
        if (full_page) begin
            wrap_mask = '1;
        end else begin
            wrap_mask = COL_W'((32'd1 << log_len) - 32'd1);
        end
    end

    // Purpose: force sequential order when the burst covers a full page.
    always_comb begin
        if (full_page || (order_in == 1'b0)) begin
            order_out = ORD_SEQ;
        end else begin
            order_out = ORD_INTL;
        end
    end
endmodule

// File: rtl/colgen_addr_calc.sv
// Module: colgen_addr_calc
// Forms the column of beat n from the base column, the beat count and the wrap mask.
// Assumes: the count never exceeds the mask in fixed-length bursts.
module colgen_addr_calc
    import colgen_pkg::*;
#(
    parameter int COL_W = 11
) (
    input  logic [COL_W-1:0] base_col,
    input  logic [COL_W-1:0] beat_cnt,
    input  logic [COL_W-1:0] wrap_mask,
    input  burst_order_e     order,
    output logic [COL_W-1:0] col
);
    logic [COL_W-1:0] seq_sum;

    // Purpose: the sequential offset; carries only move upward, so the masked bits are exact.
    always_comb begin
        seq_sum = base_col + beat_cnt;
    end

    // Purpose: each column bit takes the base value outside the mask, and the stepped value inside it.
    for (genvar gi = 0; gi < COL_W; gi++) begin : g_bit
        always_comb begin
            if (!wrap_mask[gi]) begin
                col[gi] = base_col[gi];
            end else if (order == ORD_INTL) begin
                col[gi] = base_col[gi] ^ beat_cnt[gi];
            end else begin
                col[gi] = seq_sum[gi];
            end
        end
    end
endmodule

// File: rtl/colgen_beat_ctrl.sv
// Module: colgen_beat_ctrl
// Holds the burst state: active flag, beat count, base column and captured mode.
// Assumes: a start takes priority over a stop sampled on the same edge.
module colgen_beat_ctrl
    import colgen_pkg::*;
#(
    parameter int COL_W = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_start,
    input  logic             cmd_stop,
    input  logic [COL_W-1:0] start_col,
    input  logic [COL_W-1:0] mask_in,
    input  logic             full_in,
    input  burst_order_e     order_in,
    output logic             active,
    output logic [COL_W-1:0] beat_cnt,
    output logic [COL_W-1:0] base_col,
    output logic [COL_W-1:0] mask_q,
    output logic             full_q,
    output burst_order_e     order_q,
    output logic             at_last
);
    // Purpose: flag the final beat of a fixed-length burst.
    always_comb begin
        at_last = active && !full_q && (beat_cnt == mask_q);
    end

    // Purpose: load on a command, clear on a stop or after the last beat, otherwise step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active   <= 1'b0;
            beat_cnt <= '0;
            base_col <= '0;
            mask_q   <= '0;
            full_q   <= 1'b0;
            order_q  <= ORD_SEQ;
        end else if (cmd_start) begin
            active   <= 1'b1;
            beat_cnt <= '0;
            base_col <= start_col;
            mask_q   <= mask_in;
            full_q   <= full_in;
            order_q  <= order_in;
        end else if (cmd_stop) begin
            active   <= 1'b0;
        end else if (active) begin
            if (at_last) begin
                active <= 1'b0;
            end else begin
                beat_cnt <= beat_cnt + 1'b1;
            end
        end
    end

    // R11: the captured mode holds while a burst runs and no command arrives
    a_r11_mode_held: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !cmd_start) |=> ($stable(mask_q) && $stable(full_q) && $stable(order_q)));

    // R2: a beat that is not the last, with no command, advances the count by one
    a_r2_step_one: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !at_last && !cmd_start && !cmd_stop) |=> (active && beat_cnt == $past(beat_cnt) + 1'b1));
endmodule

// File: rtl/sdram_burst_colgen.sv
// Module: sdram_burst_colgen (top)
// Generates one column address per clock for an SDRAM burst, with valid and last-beat flags.
// Assumes: inputs are synchronous to clk; the mode fields are meaningful only with cmd_start.
module sdram_burst_colgen
    import colgen_pkg::*;
#(
    parameter int COL_W = 11
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   cmd_start,
    input  logic                   cmd_stop,
    input  logic [COL_W-1:0]       start_col,
    input  logic [LEN_FIELD_W-1:0] bl_code,
    input  logic                   intl_sel,
    output logic [COL_W-1:0]       col_out,
    output logic                   beat_valid,
    output logic                   beat_last
);
    logic [COL_W-1:0] dec_mask;
    logic             dec_full;
    burst_order_e     dec_order;
    logic             st_active;
    logic [COL_W-1:0] st_cnt;
    logic [COL_W-1:0] st_base;
    logic [COL_W-1:0] st_mask;
    logic             st_full;
    burst_order_e     st_order;
    logic             st_last;

    colgen_mode_dec #(.COL_W(COL_W)) i_mode_dec (
        .len_code  (bl_code),
        .order_in  (intl_sel),
        .wrap_mask (dec_mask),
        .full_page (dec_full),
        .order_out (dec_order)
    );

    colgen_beat_ctrl #(.COL_W(COL_W)) i_beat_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_start (cmd_start),
        .cmd_stop  (cmd_stop),
        .start_col (start_col),
        .mask_in   (dec_mask),
        .full_in   (dec_full),
        .order_in  (dec_order),
        .active    (st_active),
        .beat_cnt  (st_cnt),
        .base_col  (st_base),
        .mask_q    (st_mask),
        .full_q    (st_full),
        .order_q   (st_order),
        .at_last   (st_last)
    );

    colgen_addr_calc #(.COL_W(COL_W)) i_addr_calc (
        .base_col  (st_base),
        .beat_cnt  (st_cnt),
        .wrap_mask (st_mask),
        .order     (st_order),
        .col       (col_out)
    );

    // Purpose: drive the beat flags from the burst state.
    always_comb begin
        beat_valid = st_active;
        beat_last  = st_last;
    end

    // R2: a sampled command presents its start column on the next cycle
    a_r2_first_beat: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_start |=> (beat_valid && col_out == $past(start_col)));

    // R9: a stop without a command ends the burst
    a_r9_stop_ends: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_stop && !cmd_start) |=> !beat_valid);

    // R8: nothing follows the last beat unless a new command arrives
    a_r8_after_last: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_last && !cmd_start) |=> !beat_valid);

    // R6: a full-page burst never raises the last-beat flag
    a_r6_full_no_last: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_start && bl_code[FULL_PAGE_BIT]) |=> !beat_last);

    // R8: a last beat can occur only during a valid burst
    a_r8_last_in_burst: assert property (@(posedge clk) disable iff (!rst_n)
        beat_last |-> beat_valid);
endmodule

// File: tb/test_sdram_burst_colgen.sv
`timescale 1ns/1ps
module test_sdram_burst_colgen;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_start = 1'b0;
    logic        cmd_stop = 1'b0;
    logic [10:0] start_col = '0;
    logic [2:0]  bl_code = '0;
    logic        intl_sel = 1'b0;
    logic [10:0] col_out;
    logic        beat_valid;
    logic        beat_last;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #4 clk = ~clk;

    sdram_burst_colgen i_sdram_burst_colgen (
        .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .cmd_stop(cmd_stop),
        .start_col(start_col), .bl_code(bl_code), .intl_sel(intl_sel),
        .col_out(col_out), .beat_valid(beat_valid), .beat_last(beat_last)
    );

    // Column that the requirements give for beat k
    function automatic logic [10:0] exp_col(logic [10:0] s, logic [2:0] code, logic intl, int k);
        logic [10:0] m;
        logic [10:0] kk;
        kk = 11'(k);
        m  = code[2] ? 11'h7FF : 11'((1 << code[1:0]) - 1);
        if (intl && !code[2]) return (s & ~m) | ((s ^ kk) & m);
        return (s & ~m) | ((s + kk) & m);
    endfunction

    task automatic expect_beat(string req, logic [10:0] col, bit last);
        n_tests++;
        if (beat_valid !== 1'b1 || col_out !== col || beat_last !== last) begin
            n_fail++;
            $display("FAIL %s: col=%0d valid=%0b last=%0b, expected col=%0d valid=1 last=%0b",
                     req, col_out, beat_valid, beat_last, col, last);
        end
    endtask

    task automatic expect_idle(string req);
        n_tests++;
        if (beat_valid !== 1'b0 || beat_last !== 1'b0) begin
            n_fail++;
            $display("FAIL %s: valid=%0b last=%0b, expected valid=0 last=0", req, beat_valid, beat_last);
        end
    endtask

    // Drive a command at a falling edge; returns at the next falling edge with beat 0 shown
    task automatic launch(logic [10:0] s, logic [2:0] code, logic intl, bit with_stop);
        start_col = s; bl_code = code; intl_sel = intl;
        cmd_start = 1'b1; cmd_stop = with_stop;
        @(negedge clk);
        cmd_start = 1'b0; cmd_stop = 1'b0;
    endtask

    // Check a complete fixed-length burst and the idle cycle after it
    task automatic full_burst(string req, logic [10:0] s, logic [2:0] code, logic intl);
        int len;
        len = 1 << code[1:0];
        launch(s, code, intl, 1'b0);
        for (int k = 0; k < len; k++) begin
            expect_beat(req, exp_col(s, code, intl, k), k == len - 1);
            @(negedge clk);
        end
        expect_idle({req, " end"});
    endtask

    task automatic t_reset();
        // R1: outputs cleared during and after reset
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        n_tests++;
        if (beat_valid !== 1'b0 || beat_last !== 1'b0 || col_out !== 11'd0) begin
            n_fail++;
            $display("FAIL R1: col=%0d valid=%0b last=%0b, expected 0 0 0", col_out, beat_valid, beat_last);
        end
        rst_n = 1'b1;
        @(negedge clk);
        expect_idle("R1 after release");
    endtask

    task automatic t_lengths();
        // R3, R8: each fixed length, counting beats and the last flag
        full_burst("R3 len1", 11'd9, 3'd0, 1'b0);
        full_burst("R3 len2", 11'd7, 3'd1, 1'b0);
        full_burst("R3 len8", 11'd3, 3'd3, 1'b0);
    endtask

    task automatic t_seq_wrap();
        // R4: BL=4 from 2 gives 2,3,0,1; upper bits held with start 0x406
        full_burst("R4 wrap", 11'd2, 3'd2, 1'b0);
        full_burst("R4 upper", 11'h406, 3'd2, 1'b0);
        launch(11'd2, 3'd2, 1'b0, 1'b0);
        expect_beat("R4 literal b0", 11'd2, 1'b0); @(negedge clk);
        expect_beat("R4 literal b1", 11'd3, 1'b0); @(negedge clk);
        expect_beat("R4 literal b2", 11'd0, 1'b0); @(negedge clk);
        expect_beat("R4 literal b3", 11'd1, 1'b1); @(negedge clk);
        expect_idle("R8 after literal");
    endtask

    task automatic t_interleave();
        // R5: BL=8 from 5 gives 5,4,7,6,1,0,3,2
        logic [10:0] seq [8] = '{11'd5, 11'd4, 11'd7, 11'd6, 11'd1, 11'd0, 11'd3, 11'd2};
        launch(11'd5, 3'd3, 1'b1, 1'b0);
        for (int k = 0; k < 8; k++) begin
            expect_beat("R5 bl8", seq[k], k == 7);
            @(negedge clk);
        end
        expect_idle("R5 end");
        full_burst("R5 bl4 upper", 11'h52E, 3'd2, 1'b1);
        full_burst("R5 bl2", 11'd11, 3'd1, 1'b1);
    endtask

    task automatic t_full_page();
        // R6: wraps past 2047, never last, stopped by cmd_stop (R9)
        launch(11'd2045, 3'd7, 1'b0, 1'b0);
        for (int k = 0; k < 20; k++) begin
            expect_beat("R6 full", 11'((2045 + k) % 2048), 1'b0);
            @(negedge clk);
        end
        cmd_stop = 1'b1;
        @(negedge clk);
        cmd_stop = 1'b0;
        expect_idle("R9 stop full page");
    endtask

    task automatic t_full_ignores_intl();
        // R7: full page with intl_sel=1 still counts 5,6,7,8,...
        launch(11'd5, 3'd4, 1'b1, 1'b0);
        for (int k = 0; k < 6; k++) begin
            expect_beat("R7 full intl", 11'(5 + k), 1'b0);
            @(negedge clk);
        end
        cmd_stop = 1'b1;
        @(negedge clk);
        cmd_stop = 1'b0;
        expect_idle("R9 stop R7");
    endtask

    task automatic t_stop_mid();
        // R9: stop after two beats of an 8-beat burst
        launch(11'd16, 3'd3, 1'b0, 1'b0);
        expect_beat("R9 b0", 11'd16, 1'b0); @(negedge clk);
        expect_beat("R9 b1", 11'd17, 1'b0);
        cmd_stop = 1'b1;
        @(negedge clk);
        cmd_stop = 1'b0;
        expect_idle("R9 stopped");
        @(negedge clk);
        expect_idle("R9 stays idle");
    endtask

    task automatic t_interrupt();
        // R10: new command after three beats replaces the burst
        launch(11'd0, 3'd3, 1'b0, 1'b0);
        expect_beat("R10 old b0", 11'd0, 1'b0); @(negedge clk);
        expect_beat("R10 old b1", 11'd1, 1'b0); @(negedge clk);
        expect_beat("R10 old b2", 11'd2, 1'b0);
        launch(11'd13, 3'd2, 1'b1, 1'b0);
        expect_beat("R10 new b0", 11'd13, 1'b0); @(negedge clk);
        expect_beat("R10 new b1", 11'd12, 1'b0); @(negedge clk);
        expect_beat("R10 new b2", 11'd15, 1'b0); @(negedge clk);
        expect_beat("R10 new b3", 11'd14, 1'b1); @(negedge clk);
        expect_idle("R10 end");
    endtask

    task automatic t_start_beats_stop();
        // R10: start and stop together -> burst begins
        launch(11'd40, 3'd1, 1'b0, 1'b1);
        expect_beat("R10 start+stop b0", 11'd40, 1'b0); @(negedge clk);
        expect_beat("R10 start+stop b1", 11'd41, 1'b1); @(negedge clk);
        expect_idle("R10 start+stop end");
    endtask

    task automatic t_mode_latched();
        // R11: fields change to full page interleaved mid-burst; BL=4 sequential from 6 continues
        launch(11'd6, 3'd2, 1'b0, 1'b0);
        bl_code = 3'd7; intl_sel = 1'b1; start_col = 11'd999;
        expect_beat("R11 b0", 11'd6, 1'b0); @(negedge clk);
        expect_beat("R11 b1", 11'd7, 1'b0); @(negedge clk);
        expect_beat("R11 b2", 11'd4, 1'b0); @(negedge clk);
        expect_beat("R11 b3", 11'd5, 1'b1); @(negedge clk);
        expect_idle("R11 end");
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_lengths();
        t_seq_wrap();
        t_interleave();
        t_full_page();
        t_full_ignores_intl();
        t_stop_mid();
        t_interrupt();
        t_start_beats_stop();
        t_mode_latched();
        // R2 is covered by every first-beat check above
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule